// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the feedback divider of an integer-N frequency synthesizer. It divides its input clock by N = B·P + A and emits one pulse per period, which feeds a phase detector. The divider clock drives a prescaler whose modulus can be P+1 or P. A swallow counter (A, 6 bits) and a main counter (B, 13 bits) count prescaler cycles. For the first A prescaler cycles of each period the prescaler divides by P+1. For the rest of the period it divides by P. When the main counter runs out, both counters reload from the settings at the inputs. All of the logic is synchronous to the single divider clock.

A synchronous counter-hold input keeps all counters at their load point. This lets software reprogram the divider and then restart it in step with the reference path. The block makes illegal settings safe before it uses them, and it raises an error flag while they are present. The analog input stage is not part of this block.

Top module: `dms_divider`

## Requirements
- R1: While running, consecutive rising edges of `div_o` are exactly N = B·P + A input clock cycles apart. B and A are the effective values defined in R4 and R5.
- R2: `psel_i` selects the prescaler base modulus P. The encoding is 0 → 8, 1 → 16, 2 → 32 and 3 → 64, and the alternate modulus is always P+1.
- R3: `div_o` is high for exactly one input clock cycle in each period.
- R4: A value of `b_i` below 3 is replaced by 3, and `cfg_err_o` is high while such a value is present.
- R5: A value of `a_i` above the effective B is replaced by the effective B, and `cfg_err_o` is high while such a value is present. With legal settings, `cfg_err_o` is low.
- R6: While `cnt_rst_i` is high, `div_o` stays low and the counters sit at their load state. The first pulse after `cnt_rst_i` is sampled low comes on the (N−1)-th rising clock edge, counting that edge as the first.
- R7: Settings are captured only at a period boundary or while the counters are held. A change in the middle of a period leaves the length of that period unchanged and applies to the next period.
- R8: After the asynchronous reset `rst_ni`, `div_o` is low, and the first period runs with B = 3, A = 0 and P = 8 (N = 24) whatever the inputs are.
- R9: The boundary cases A = 0 (giving N = B·P) and A = B (giving N = B·(P+1)) follow R1.
- R10: If `cnt_rst_i` is high in the cycle that would otherwise carry the terminal pulse, no pulse is produced, and counting restarts from the load state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divider input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_rst_i | input | 1 | Synchronous counter hold at the load point |
| psel_i | input | 2 | Prescaler modulus select |
| a_i | input | 6 | Swallow count A |
| b_i | input | 13 | Main count B |
| div_o | output | 1 | One-cycle pulse per N input cycles |
| cfg_err_o | output | 1 | Illegal A or B setting present |

## Verification
Two events can fall in the same cycle: the terminal count that produces the output pulse, and the counter hold. The bench releases the hold on a short 24-cycle configuration and counts edges until the cycle in which the pulse would appear. It raises the hold in that cycle and checks that `div_o` is low. It then releases the hold and checks that the next pulse comes a full N−1 edges later, from the load state. A second collision is between a settings change and the period boundary. The bench provokes it by changing B in the middle of a period, and it judges it by measuring the current interval and the following interval separately.

// File: rtl/dms_pkg.sv
package dms_pkg;
  localparam int A_W    = 6;
  localparam int B_W    = 13;
  localparam int PSEL_W = 2;
  localparam int PCNT_W = 7;
  localparam int P_BASE = 8;
  localparam int B_MIN  = 3;

  function automatic logic [PCNT_W-1:0] psel_to_mod(input logic [PSEL_W-1:0] sel);
    return PCNT_W'(P_BASE) << sel;
  endfunction
endpackage

// File: rtl/dms_cfg_check.sv
module dms_cfg_check #(
  parameter int A_W   = dms_pkg::A_W,
  parameter int B_W   = dms_pkg::B_W,
  parameter int B_MIN = dms_pkg::B_MIN
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [A_W-1:0] a_o,
  output logic [B_W-1:0] b_o,
  output logic           err_o
);
  localparam logic [B_W-1:0] BMIN = B_W'(B_MIN);
  logic b_bad, a_bad;

  always_comb begin
    b_bad = b_i < BMIN;
    b_o   = b_bad ? BMIN : b_i;
    a_bad = B_W'(a_i) > b_o;
    // a_bad only when b_o is below 2**A_W, so truncation is safe
    a_o   = a_bad ? b_o[A_W-1:0] : a_i;
    err_o = a_bad | b_bad;
  end
endmodule

// File: rtl/dms_prescaler.sv
module dms_prescaler #(
  parameter int PSEL_W = dms_pkg::PSEL_W,
  parameter int PCNT_W = dms_pkg::PCNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic              swallow_next_i,
  output logic              tick_o
);
  localparam logic [PCNT_W-1:0] P_RST = PCNT_W'(dms_pkg::P_BASE);

  logic [PCNT_W-1:0] p_q, pcnt_q, pm;

  assign pm     = dms_pkg::psel_to_mod(psel_i);
  assign tick_o = (pcnt_q == '0);

  // pcnt counts m..0, i.e. m+1 cycles: load P for P+1, P-1 for P
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q    <= P_RST;
      pcnt_q <= P_RST - 1'b1;
    end else if (load_i) begin
      p_q    <= pm;
      pcnt_q <= swallow_next_i ? pm : pm - 1'b1;
    end else if (tick_o) begin
      pcnt_q <= swallow_next_i ? p_q : p_q - 1'b1;
    end else begin
      pcnt_q <= pcnt_q - 1'b1;
    end
  end

  p_pcnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= p_q);
  p_mod_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(p_q) && p_q >= P_RST);
endmodule

// File: rtl/dms_counters.sv
module dms_counters #(
  parameter int A_W   = dms_pkg::A_W,
  parameter int B_W   = dms_pkg::B_W,
  parameter int B_MIN = dms_pkg::B_MIN
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hold_i,
  input  logic           tick_i,
  input  logic [A_W-1:0] a_ld_i,
  input  logic [B_W-1:0] b_ld_i,
  output logic           term_o,
  output logic           swallow_next_o
);
  logic [A_W-1:0] a_q, a_nxt;
  logic [B_W-1:0] b_q, b_nxt;
  logic           load;

  assign term_o = tick_i && (b_q == B_W'(1));
  assign load   = hold_i | term_o;

  always_comb begin
    a_nxt = a_q;
    b_nxt = b_q;
    if (load) begin
      a_nxt = a_ld_i;
      b_nxt = b_ld_i;
    end else if (tick_i) begin
      a_nxt = (a_q != '0) ? a_q - 1'b1 : a_q;
      b_nxt = b_q - 1'b1;
    end
  end

  assign swallow_next_o = (a_nxt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= B_W'(B_MIN);
    end else begin
      a_q <= a_nxt;
      b_q <= b_nxt;
    end
  end

  p_a_le_b_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    B_W'(a_q) <= b_q && b_q != '0);
  p_hold_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (b_q == $past(b_ld_i)) && (a_q == $past(a_ld_i)));
  p_term_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |=> b_q == $past(b_ld_i));
endmodule

// File: rtl/dms_divider.sv
module dms_divider #(
  parameter int A_W    = dms_pkg::A_W,
  parameter int B_W    = dms_pkg::B_W,
  parameter int PSEL_W = dms_pkg::PSEL_W,
  parameter int PCNT_W = dms_pkg::PCNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_rst_i,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic [A_W-1:0]    a_i,
  input  logic [B_W-1:0]    b_i,
  output logic              div_o,
  output logic              cfg_err_o
);
  logic [A_W-1:0] a_eff;
  logic [B_W-1:0] b_eff;
  logic           tick, term, swallow_next;

  dms_cfg_check #(.A_W(A_W), .B_W(B_W)) u_cfg (
    .a_i(a_i), .b_i(b_i), .a_o(a_eff), .b_o(b_eff), .err_o(cfg_err_o)
  );

  dms_prescaler #(.PSEL_W(PSEL_W), .PCNT_W(PCNT_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cnt_rst_i | term),
    .psel_i(psel_i), .swallow_next_i(swallow_next), .tick_o(tick)
  );

  dms_counters #(.A_W(A_W), .B_W(B_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(cnt_rst_i), .tick_i(tick),
    .a_ld_i(a_eff), .b_ld_i(b_eff), .term_o(term), .swallow_next_o(swallow_next)
  );

  assign div_o = term & ~cnt_rst_i;

  p_pulse_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);
  p_cfg_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_eff >= B_W'(dms_pkg::B_MIN) && B_W'(a_eff) <= b_eff);
endmodule

// File: tb/dms_divider_bench.sv
module dms_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_rst = 1'b1;
  logic [1:0]  psel = '0;
  logic [5:0]  a_v = '0;
  logic [12:0] b_v = 13'd3;
  logic        div, cfg_err;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dms_divider u_dms_divider (
    .clk_i(clk), .rst_ni(rst_n), .cnt_rst_i(cnt_rst), .psel_i(psel),
    .a_i(a_v), .b_i(b_v), .div_o(div), .cfg_err_o(cfg_err)
  );

  localparam int NV = 9;
  localparam int V_PSEL[NV] = '{0, 1, 2, 3, 0, 1, 0, 2, 3};
  localparam int V_A[NV]    = '{5, 0, 7, 63, 0, 2, 9, 1, 0};
  localparam int V_B[NV]    = '{10, 3, 7, 63, 0, 1, 4, 100, 5};

  function automatic int calc_b(input int b);
    return (b < 3) ? 3 : b;
  endfunction
  function automatic int calc_a(input int a, input int b);
    return (a > calc_b(b)) ? calc_b(b) : a;
  endfunction
  function automatic int calc_n(input int p, input int a, input int b);
    return calc_b(b) * (8 << p) + calc_a(a, b);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_to_pulse(output int k);
    k = 0;
    do begin
      @(posedge clk); @(negedge clk);
      k++;
    end while (!div && k < 10000);
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k, n;
    // R8: reset state, counting from reset with hold low
    cnt_rst = 1'b0; psel = 2'd1; a_v = '0; b_v = 13'd3;
    edges(3);
    check("R8 div low in reset", int'(div), 0);
    check("R5 no error on legal settings", int'(cfg_err), 0);
    rst_n = 1'b1;
    count_to_pulse(k);
    check("R8 first period from reset state", k, 23);
    count_to_pulse(k);
    check("R8 next period uses inputs (P=16)", k, 48);

    // vector table: R1 R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      cnt_rst = 1'b1;
      psel = 2'(V_PSEL[i]); a_v = 6'(V_A[i]); b_v = 13'(V_B[i]);
      n = calc_n(V_PSEL[i], V_A[i], V_B[i]);
      #1;
      check("R4/R5 cfg_err_o", int'(cfg_err),
            int'(V_B[i] < 3 || V_A[i] > calc_b(V_B[i])));
      edges(2);
      check("R6 div low while held", int'(div), 0);
      cnt_rst = 1'b0;
      count_to_pulse(k);
      check("R6 first pulse after release", k, n - 1);
      @(posedge clk); @(negedge clk);
      check("R3 pulse one cycle wide", int'(div), 0);
      count_to_pulse(k);
      check("R1 R2 R9 period length", k + 1, n);
    end

    // R7: mid-period change applies next period
    cnt_rst = 1'b1; psel = 2'd0; a_v = '0; b_v = 13'd3;
    edges(2);
    cnt_rst = 1'b0;
    edges(5);
    b_v = 13'd10;
    count_to_pulse(k);
    check("R7 current period keeps old N", k + 5, 23);
    count_to_pulse(k);
    check("R7 next period uses new N", k, 80);

    // R10: hold in the terminal cycle suppresses the pulse
    cnt_rst = 1'b1; b_v = 13'd3;
    edges(2);
    cnt_rst = 1'b0;
    edges(22);
    check("R10 no early pulse", int'(div), 0);
    edges(1);
    check("R10 terminal cycle reached", int'(div), 1);
    cnt_rst = 1'b1;
    #1;
    check("R10 pulse suppressed by hold", int'(div), 0);
    @(negedge clk);
    cnt_rst = 1'b0;
    count_to_pulse(k);
    check("R10 restart from load state", k, 23);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule